// File: doc/BRIEF.md
# Serial Servo Command Register Decoder

This block sits between a host controller and the switch network of an optical-disc servo front end. The host sends 8-bit commands on a three-wire serial port: a shift clock, a data line and an active-low latch strobe. The block samples all three with its own system clock. When the strobe returns high, the block takes the upper nibble of the byte as a register address and the lower nibble as the payload.

Three control registers hold the focus settings, the tracking gain, brake and kick settings, and the tracking and sled operating modes. The block decodes them into individual switch enables. The address of the last latched byte also decides what appears on a shared sense line. That can be one of three status inputs, a forced low level, or nothing: the output enable drops and the line can float.

Top module: `servo_cmd_decoder`

## Requirements
- R1: After reset all switch enables are 0 except `dfct_en`, which is 1, `kick_code` is 00, and the sense line is released (`sense_oe`=0, `sense_out`=0).
- R2: The block samples `ser_data` on each rising edge of `ser_clk`, with bit 0 first and bit 7 last. A command takes effect only when `ser_latch_n` rises, and then only the last eight bits shifted in are used. Shifting without a latch changes no output.
- R3: Address 0 writes the focus register. Bit 3 drives `focus_on` and bit 1 drives `srch_on`. Bit 0 drives `srch_up`. Bit 2 set to 1 clears `dfct_en`, and bit 2 set to 0 sets it.
- R4: Address 1 writes the tracking-control register. Bit 3 drives `gain_hi` and bit 2 drives `brake_on`. Bits 1:0 appear on `kick_code`, where 00 to 11 stand for kick heights 1 to 4.
- R5: Address 2 bits 3:2 select the tracking mode: 00 off, 01 servo (`trk_servo`), 10 forward jump (`jump_fwd`), 11 reverse jump (`jump_rev`). At most one of the three is active.
- R6: Address 2 bits 1:0 select the sled mode: 00 off, 01 servo (`sled_servo`), 10 forward move (`sled_fwd`), 11 reverse move (`sled_rev`). At most one of the three is active.
- R7: After a latched address of 0, 1 or 2, `sense_oe` is 1 and `sense_out` follows `fzc_in`, `dfct_in` or `tzc_in` respectively. It keeps following that input until the next latched command.
- R8: A latched address of 3 changes no control register and drives the sense line low with `sense_oe`=1.
- R9: A latched address from 4 to 15 changes no control register and releases the sense line (`sense_oe`=0, `sense_out`=0).
- R10: A write to one control register leaves the outputs decoded from the other two registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than `ser_clk` |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_clk | input | 1 | Serial shift clock from the host |
| ser_data | input | 1 | Serial data, bit 0 first |
| ser_latch_n | input | 1 | Active-low latch strobe; the command applies on its rising edge |
| fzc_in | input | 1 | Focus zero-cross status |
| dfct_in | input | 1 | Defect status |
| tzc_in | input | 1 | Tracking zero-cross status |
| focus_on | output | 1 | Focus loop switch closed |
| dfct_en | output | 1 | Defect-hold switching enabled |
| srch_on | output | 1 | Focus search drive on |
| srch_up | output | 1 | Focus search direction up |
| gain_hi | output | 1 | Tracking high-gain switch pair |
| brake_on | output | 1 | Tracking brake enable |
| kick_code | output | 2 | Sled kick height code |
| trk_servo | output | 1 | Tracking servo switch |
| jump_fwd | output | 1 | Forward track-jump source |
| jump_rev | output | 1 | Reverse track-jump source |
| sled_servo | output | 1 | Sled servo switch |
| sled_fwd | output | 1 | Forward sled-move source |
| sled_rev | output | 1 | Reverse sled-move source |
| sense_out | output | 1 | Shared sense line value |
| sense_oe | output | 1 | Sense line drive enable; 0 means high impedance |

## Verification
On every cycle, the assertions check three things. The switch outputs hold steady except in the cycle after a decoded command. Writes to addresses 0, 1 and 2 land in the right output fields. Addresses 3 and above leave the control outputs alone and set the sense line to its low or released state.

Some behaviour only the bench scenarios can show. These are the serial bit order and the rule that a partial shift has no effect. Another is that the sense line keeps tracking its selected status input long after the command. The last is that registers stay independent across a long sequence of mixed commands.

// File: rtl/scd_pkg.sv
// Package: shared widths and types of the serial servo command decoder.
// Assumes an 8-bit command split into a 4-bit address and a 4-bit payload.
package scd_pkg;
    localparam int CMD_W   = 8;
    localparam int FIELD_W = CMD_W / 2;

    // What the shared sense line carries
    typedef enum logic [2:0] {
        SNS_FZC  = 3'd0,
        SNS_DFCT = 3'd1,
        SNS_TZC  = 3'd2,
        SNS_LOW  = 3'd3,
        SNS_HIZ  = 3'd4
    } sns_sel_e;

    // Two-bit actuator mode shared by tracking and sled fields
    typedef enum logic [1:0] {
        MODE_OFF   = 2'b00,
        MODE_SERVO = 2'b01,
        MODE_FWD   = 2'b10,
        MODE_REV   = 2'b11
    } act_mode_e;

    typedef struct packed {
        logic loop_on;
        logic dfct_dis;
        logic srch_on;
        logic srch_up;
    } focus_reg_t;

    typedef struct packed {
        logic       gain_hi;
        logic       brake;
        logic [1:0] kick;
    } trk_reg_t;

    typedef struct packed {
        act_mode_e trk;
        act_mode_e sled;
    } mode_reg_t;
endpackage

// File: rtl/scd_sync.sv
// Module: scd_sync
// Brings one asynchronous input into the clk domain through a flop chain.
// Assumes STAGES >= 2; RST_VAL is the idle level of the input.
module scd_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    // Shift the input through the synchronizer chain
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= {STAGES{RST_VAL}};
        else        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/scd_shift_rx.sv
// Module: scd_shift_rx
// Oversamples the serial port, shifts data in LSB first on each rising
// shift-clock edge and emits a one-cycle command strobe on the latch rise.
// Assumes each serial phase lasts several clk periods.
module scd_shift_rx
    import scd_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ser_clk,
    input  logic             ser_data,
    input  logic             ser_latch_n,
    output logic             cmd_vld,
    output logic [CMD_W-1:0] cmd_byte
);
    logic sclk_s, sdat_s, slat_s;
    logic sclk_d, slat_d;
    logic sclk_rise, slat_rise;
    logic [CMD_W-1:0] shreg;

    scd_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_clk (
        .clk(clk), .rst_n(rst_n), .d(ser_clk), .q(sclk_s));
    scd_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_dat (
        .clk(clk), .rst_n(rst_n), .d(ser_data), .q(sdat_s));
    scd_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_lat (
        .clk(clk), .rst_n(rst_n), .d(ser_latch_n), .q(slat_s));

    // Remember previous synchronized levels for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_d <= 1'b0;
            slat_d <= 1'b1;
        end else begin
            sclk_d <= sclk_s;
            slat_d <= slat_s;
        end
    end

    assign sclk_rise = sclk_s & ~sclk_d;
    assign slat_rise = slat_s & ~slat_d;

    // Shift data in on shift-clock rise; first bit ends in position 0
    always_ff @(posedge clk) begin
        if (!rst_n)         shreg <= '0;
        else if (sclk_rise) shreg <= {sdat_s, shreg[CMD_W-1:1]};
    end

    // Present the assembled byte for one cycle on latch rise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_vld  <= 1'b0;
            cmd_byte <= '0;
        end else begin
            cmd_vld <= slat_rise;
            if (slat_rise) cmd_byte <= shreg;
        end
    end
endmodule

// File: rtl/scd_regfile.sv
// Module: scd_regfile
// Holds the three control nibbles and the sense selection, written by a
// decoded command. Addresses 3 and above write no control register.
module scd_regfile
    import scd_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_vld,
    input  logic [CMD_W-1:0] cmd_byte,
    output focus_reg_t       focus_q,
    output trk_reg_t         trk_q,
    output mode_reg_t        mode_q,
    output sns_sel_e         sel_q
);
    logic [FIELD_W-1:0] addr;
    logic [FIELD_W-1:0] payload;

    assign addr    = cmd_byte[CMD_W-1:FIELD_W];
    assign payload = cmd_byte[FIELD_W-1:0];

    // Write the addressed control register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            focus_q <= '0;
            trk_q   <= '0;
            mode_q  <= '{trk: MODE_OFF, sled: MODE_OFF};
        end else if (cmd_vld) begin
            case (addr)
                FIELD_W'(0): focus_q <= focus_reg_t'(payload);
                FIELD_W'(1): trk_q   <= trk_reg_t'(payload);
                FIELD_W'(2): mode_q  <= mode_reg_t'(payload);
                default: ;
            endcase
        end
    end

    // Track the sense selection from every latched address
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= SNS_HIZ;
        end else if (cmd_vld) begin
            case (addr)
                FIELD_W'(0): sel_q <= SNS_FZC;
                FIELD_W'(1): sel_q <= SNS_DFCT;
                FIELD_W'(2): sel_q <= SNS_TZC;
                FIELD_W'(3): sel_q <= SNS_LOW;
                default:     sel_q <= SNS_HIZ;
            endcase
        end
    end
endmodule

// File: rtl/scd_switch_dec.sv
// Module: scd_switch_dec
// Turns the stored control fields into switch enables and routes the
// selected status input to the sense line. Purely combinational.
module scd_switch_dec
    import scd_pkg::*;
(
    input  focus_reg_t focus_q,
    input  trk_reg_t   trk_q,
    input  mode_reg_t  mode_q,
    input  sns_sel_e   sel_q,
    input  logic       fzc_in,
    input  logic       dfct_in,
    input  logic       tzc_in,
    output logic       focus_on,
    output logic       dfct_en,
    output logic       srch_on,
    output logic       srch_up,
    output logic       gain_hi,
    output logic       brake_on,
    output logic [1:0] kick_code,
    output logic [2:0] trk_sw,
    output logic [2:0] sled_sw,
    output logic       sense_out,
    output logic       sense_oe
);
    // Map focus and tracking-control fields onto their switches
    always_comb begin
        focus_on  = focus_q.loop_on;
        dfct_en   = ~focus_q.dfct_dis;
        srch_on   = focus_q.srch_on;
        srch_up   = focus_q.srch_up;
        gain_hi   = trk_q.gain_hi;
        brake_on  = trk_q.brake;
        kick_code = trk_q.kick;
    end

    // Decode each two-bit mode into servo / forward / reverse enables
    for (genvar g = 0; g < 2; g++) begin : g_mode
        act_mode_e  m;
        logic [2:0] sw;
        assign m = (g == 0) ? mode_q.trk : mode_q.sled;
        always_comb begin
            sw[0] = (m == MODE_SERVO);
            sw[1] = (m == MODE_FWD);
            sw[2] = (m == MODE_REV);
        end
        if (g == 0) begin : g_trk
            assign trk_sw = sw;
        end else begin : g_sled
            assign sled_sw = sw;
        end
    end

    // Route the chosen status onto the sense line
    always_comb begin
        sense_oe  = 1'b1;
        sense_out = 1'b0;
        case (sel_q)
            SNS_FZC:  sense_out = fzc_in;
            SNS_DFCT: sense_out = dfct_in;
            SNS_TZC:  sense_out = tzc_in;
            SNS_LOW:  sense_out = 1'b0;
            default:  sense_oe  = 1'b0;
        endcase
    end
endmodule

// File: rtl/servo_cmd_decoder.sv
// Module: servo_cmd_decoder
// Top of the serial servo command decoder: serial receiver, register file
// and switch decoder. Assumes clk runs at several times the shift clock.
module servo_cmd_decoder
    import scd_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ser_clk,
    input  logic       ser_data,
    input  logic       ser_latch_n,
    input  logic       fzc_in,
    input  logic       dfct_in,
    input  logic       tzc_in,
    output logic       focus_on,
    output logic       dfct_en,
    output logic       srch_on,
    output logic       srch_up,
    output logic       gain_hi,
    output logic       brake_on,
    output logic [1:0] kick_code,
    output logic       trk_servo,
    output logic       jump_fwd,
    output logic       jump_rev,
    output logic       sled_servo,
    output logic       sled_fwd,
    output logic       sled_rev,
    output logic       sense_out,
    output logic       sense_oe
);
    logic             cmd_vld;
    logic [CMD_W-1:0] cmd_byte;
    focus_reg_t       focus_q;
    trk_reg_t         trk_q;
    mode_reg_t        mode_q;
    sns_sel_e         sel_q;
    logic [2:0]       trk_sw;
    logic [2:0]       sled_sw;

    scd_shift_rx #(.SYNC_STAGES(SYNC_STAGES)) u_rx (
        .clk(clk), .rst_n(rst_n),
        .ser_clk(ser_clk), .ser_data(ser_data), .ser_latch_n(ser_latch_n),
        .cmd_vld(cmd_vld), .cmd_byte(cmd_byte));

    scd_regfile u_regs (
        .clk(clk), .rst_n(rst_n),
        .cmd_vld(cmd_vld), .cmd_byte(cmd_byte),
        .focus_q(focus_q), .trk_q(trk_q), .mode_q(mode_q), .sel_q(sel_q));

    scd_switch_dec u_dec (
        .focus_q(focus_q), .trk_q(trk_q), .mode_q(mode_q), .sel_q(sel_q),
        .fzc_in(fzc_in), .dfct_in(dfct_in), .tzc_in(tzc_in),
        .focus_on(focus_on), .dfct_en(dfct_en), .srch_on(srch_on),
        .srch_up(srch_up), .gain_hi(gain_hi), .brake_on(brake_on),
        .kick_code(kick_code), .trk_sw(trk_sw), .sled_sw(sled_sw),
        .sense_out(sense_out), .sense_oe(sense_oe));

    assign trk_servo  = trk_sw[0];
    assign jump_fwd   = trk_sw[1];
    assign jump_rev   = trk_sw[2];
    assign sled_servo = sled_sw[0];
    assign sled_fwd   = sled_sw[1];
    assign sled_rev   = sled_sw[2];
endmodule

// File: rtl/servo_cmd_decoder_chk.sv
// Module: servo_cmd_decoder_chk
// Temporal checks on the decoder outputs against the decoded command strobe.
module servo_cmd_decoder_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_vld,
    input logic [7:0] cmd_byte,
    input logic       focus_on,
    input logic       dfct_en,
    input logic       srch_on,
    input logic       srch_up,
    input logic       gain_hi,
    input logic       brake_on,
    input logic [1:0] kick_code,
    input logic       trk_servo,
    input logic       jump_fwd,
    input logic       jump_rev,
    input logic       sled_servo,
    input logic       sled_fwd,
    input logic       sled_rev,
    input logic       sense_out,
    input logic       sense_oe
);
    logic [13:0] ctrl;
    logic [3:0]  addr;
    assign ctrl = {focus_on, dfct_en, srch_on, srch_up, gain_hi, brake_on,
                   kick_code, trk_servo, jump_fwd, jump_rev,
                   sled_servo, sled_fwd, sled_rev};
    assign addr = cmd_byte[7:4];

    // R1
    reset_vals_chk: assert property (@(posedge clk)
        !rst_n |=> (ctrl == 14'b01_0000_0000_0000) && !sense_oe && !sense_out);

    // R2
    hold_between_cmds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_vld |=> $stable(ctrl));

    // R3
    focus_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_vld && addr == 4'd0) |=>
        ({focus_on, !dfct_en, srch_on, srch_up} == $past(cmd_byte[3:0])));

    // R4
    trk_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_vld && addr == 4'd1) |=>
        ({gain_hi, brake_on, kick_code} == $past(cmd_byte[3:0])));

    // R5
    jump_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_vld && addr == 4'd2) |=>
        ($countones({trk_servo, jump_fwd, jump_rev}) == (($past(cmd_byte[3:2]) != 2'b00) ? 1 : 0)));

    // R6
    sled_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_vld && addr == 4'd2) |=>
        ($countones({sled_servo, sled_fwd, sled_rev}) == (($past(cmd_byte[1:0]) != 2'b00) ? 1 : 0)));

    // R8
    addr3_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_vld && addr == 4'd3) |=> $stable(ctrl) && sense_oe && !sense_out);

    // R9
    hiz_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_vld && addr >= 4'd4) |=> $stable(ctrl) && !sense_oe && !sense_out);
endmodule

bind servo_cmd_decoder servo_cmd_decoder_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cmd_vld(cmd_vld), .cmd_byte(cmd_byte),
    .focus_on(focus_on), .dfct_en(dfct_en), .srch_on(srch_on),
    .srch_up(srch_up), .gain_hi(gain_hi), .brake_on(brake_on),
    .kick_code(kick_code), .trk_servo(trk_servo), .jump_fwd(jump_fwd),
    .jump_rev(jump_rev), .sled_servo(sled_servo), .sled_fwd(sled_fwd),
    .sled_rev(sled_rev), .sense_out(sense_out), .sense_oe(sense_oe));

// File: tb/servo_cmd_decoder_tb.sv
// Scoreboard bench: the driver sends commands and queues the expected
// output vector; the monitor compares it once the command has settled.
module servo_cmd_decoder_tb;
    localparam int CLK_PERIOD = 10;
    localparam int PHASE      = 8;
    localparam int SETTLE     = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_clk = 1'b0, ser_data = 1'b0, ser_latch_n = 1'b1;
    logic fzc_in = 1'b0, dfct_in = 1'b0, tzc_in = 1'b0;
    logic focus_on, dfct_en, srch_on, srch_up, gain_hi, brake_on;
    logic [1:0] kick_code;
    logic trk_servo, jump_fwd, jump_rev, sled_servo, sled_fwd, sled_rev;
    logic sense_out, sense_oe;

    int n_checks = 0;
    int n_bad    = 0;
    bit done     = 1'b0;

    logic [15:0] exp_q[$];
    string       tag_q[$];

    logic [3:0] m_foc = 4'h0, m_trk = 4'h0, m_mode = 4'h0;
    int         m_sel = 4;

    always #(CLK_PERIOD/2) clk = ~clk;

    servo_cmd_decoder u_dut (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data),
        .ser_latch_n(ser_latch_n), .fzc_in(fzc_in), .dfct_in(dfct_in),
        .tzc_in(tzc_in), .focus_on(focus_on), .dfct_en(dfct_en),
        .srch_on(srch_on), .srch_up(srch_up), .gain_hi(gain_hi),
        .brake_on(brake_on), .kick_code(kick_code), .trk_servo(trk_servo),
        .jump_fwd(jump_fwd), .jump_rev(jump_rev), .sled_servo(sled_servo),
        .sled_fwd(sled_fwd), .sled_rev(sled_rev), .sense_out(sense_out),
        .sense_oe(sense_oe));

    function automatic logic [15:0] model_vec();
        logic [15:0] v;
        v[15]  = m_foc[3];
        v[14]  = ~m_foc[2];
        v[13]  = m_foc[1];
        v[12]  = m_foc[0];
        v[11]  = m_trk[3];
        v[10]  = m_trk[2];
        v[9:8] = m_trk[1:0];
        v[7]   = (m_mode[3:2] == 2'b01);
        v[6]   = (m_mode[3:2] == 2'b10);
        v[5]   = (m_mode[3:2] == 2'b11);
        v[4]   = (m_mode[1:0] == 2'b01);
        v[3]   = (m_mode[1:0] == 2'b10);
        v[2]   = (m_mode[1:0] == 2'b11);
        case (m_sel)
            0:       v[1:0] = {1'b1, fzc_in};
            1:       v[1:0] = {1'b1, dfct_in};
            2:       v[1:0] = {1'b1, tzc_in};
            3:       v[1:0] = 2'b10;
            default: v[1:0] = 2'b00;
        endcase
        return v;
    endfunction

    task automatic push_check(input string tag);
        exp_q.push_back(model_vec());
        tag_q.push_back(tag);
        wait (exp_q.size() == 0);
    endtask

    task automatic shift_bits(input logic [7:0] b, input int n);
        for (int i = 0; i < n; i++) begin
            ser_data = b[i];
            repeat (PHASE) @(negedge clk);
            ser_clk = 1'b1;
            repeat (PHASE) @(negedge clk);
            ser_clk = 1'b0;
        end
    endtask

    task automatic send_cmd(input logic [7:0] b, input string tag);
        shift_bits(b, 8);
        repeat (PHASE) @(negedge clk);
        ser_latch_n = 1'b0;
        repeat (PHASE) @(negedge clk);
        ser_latch_n = 1'b1;
        case (b[7:4])
            4'd0: begin m_foc  = b[3:0]; m_sel = 0; end
            4'd1: begin m_trk  = b[3:0]; m_sel = 1; end
            4'd2: begin m_mode = b[3:0]; m_sel = 2; end
            4'd3: m_sel = 3;
            default: m_sel = 4;
        endcase
        push_check(tag);
    endtask

    task automatic set_status(input logic f, input logic d, input logic t);
        @(negedge clk);
        fzc_in = f; dfct_in = d; tzc_in = t;
    endtask

    // Monitor: compare each queued expectation after the command settles
    initial begin
        forever begin
            wait (exp_q.size() != 0);
            repeat (SETTLE) @(negedge clk);
            begin
                logic [15:0] act;
                act = {focus_on, dfct_en, srch_on, srch_up, gain_hi, brake_on,
                       kick_code, trk_servo, jump_fwd, jump_rev, sled_servo,
                       sled_fwd, sled_rev, sense_oe, sense_out};
                n_checks++;
                if (act !== exp_q[0]) begin
                    n_bad++;
                    $display("FAIL %s: actual=%b expected=%b", tag_q[0], act, exp_q[0]);
                end
            end
            void'(exp_q.pop_front());
            void'(tag_q.pop_front());
        end
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", n_checks, n_bad);
            $finish;
        end
    end

    // Driver
    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        push_check("R1 reset state");
        send_cmd(8'h08, "R3 focus on");
        send_cmd(8'h07, "R3 search up, defect disabled");
        set_status(1'b1, 1'b0, 1'b0);
        push_check("R7 sense follows fzc high");
        set_status(1'b0, 1'b1, 1'b1);
        push_check("R7 sense follows fzc low");
        send_cmd(8'h1D, "R4 gain brake kick01");
        push_check("R7 sense follows dfct");
        send_cmd(8'h12, "R4 kick10, R10 focus kept");
        send_cmd(8'h25, "R5 R6 servo modes");
        set_status(1'b1, 1'b1, 1'b0);
        push_check("R7 sense follows tzc");
        send_cmd(8'h2A, "R5 R6 forward");
        send_cmd(8'h2F, "R5 R6 reverse");
        send_cmd(8'h21, "R2 bit order, R6 sled servo only");
        send_cmd(8'h3F, "R8 addr3 no write, low");
        set_status(1'b1, 1'b1, 1'b1);
        push_check("R8 sense stays low");
        send_cmd(8'h4F, "R9 addr4 release");
        send_cmd(8'hA5, "R9 addr10 release");
        send_cmd(8'h0B, "R10 focus write keeps trk/mode");
        shift_bits(8'h2E, 5);
        repeat (4 * PHASE) @(negedge clk);
        push_check("R2 partial shift no effect");
        send_cmd(8'h1F, "R2 full byte after partial, R4 kick11");
        send_cmd(8'h00, "R3 focus all off");
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    end
endmodule